// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block produces a set of independent pulse-width modulated outputs, one per channel, from a single input clock. Each channel divides the clock twice: a prescaler counts input cycles into ticks, and a period counter counts ticks into one output period. The output is high for a programmed number of ticks at the start of every period and low for the rest. Software programs each channel through a single-cycle register port with two 32-bit words per channel.

Programmed values are held in a shadow copy and do not touch the running waveform until software sets the update bit. The new values then move into the active copy at the next period boundary, so a running period is never cut short or glitched. Clearing the enable bit through the same update mechanism stops the channel gracefully: it finishes its period, drives low, and puts its divider fields back to fixed defaults. An idle channel that receives update together with enable starts counting at once.

Top module: `pwm_ctrl`

## Requirements
- R1: The port uses word addresses; channel i owns word 2i (config word: period divider in bits [15:0], high count in bits [31:16]) and word 2i+1 (control word: prescale in bits [15:0], update bit 30, enable bit 31). Reads of field bits return the last written (shadow) values; unused control bits read zero.
- R2: While running, one output period lasts (prescale+1)*(divider+1) clock cycles.
- R3: The output is high for the first high_count*(prescale+1) cycles of each period and low for the rest; a high time equal to or above the period keeps the output high throughout, and a high count of zero keeps it low.
- R4: Writing either word without the update bit leaves the running waveform unchanged.
- R5: With the update bit set on a running channel, the new prescale, divider, high count and enable take effect at the first period boundary, after the running period completes.
- R6: Control-word bit 30 reads 1 while an update is waiting and 0 once it has been applied.
- R7: A control write with update and enable both set on an idle channel loads the values at that clock edge; the output shows the first cycle of the new period in the very next cycle.
- R8: An applied update with enable clear stops a running channel at its period boundary; from then on its output is low, and control-word bit 31 reads the live run state (still 1 until the stop takes effect).
- R9: When a running channel stops, its prescale field becomes 0 and its divider field becomes 1; the high count is kept.
- R10: Reads of any word address at or above 2*channel count return zero.
- R11: Reset clears every register field and holds every output low.
- R12: Channels run independently; activity on one never alters another's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, one word per cycle |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the block with its defaults: four channels and a 4-bit word address, which leaves eight unmapped words to probe for zero reads. Small prescale and divider values (periods of two to twelve cycles) put many period boundaries inside a short run, so updates can be landed at a chosen phase and the exact switch-over cycle checked. The same small settings reach the high-count corners: zero, exactly the period, and one channel toggling every cycle next to a saturated one.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int FIELD_W = 16;
  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 31;
  localparam int UPD_BIT = 30;
  localparam int PAD_W   = DATA_W - 2 - FIELD_W;
  localparam logic [FIELD_W-1:0] STOP_DIV = 16'd1;
  localparam logic [FIELD_W-1:0] STOP_PRE = 16'd0;

  typedef struct packed {
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] div;
    logic [FIELD_W-1:0] pre;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] pre_i,
  input  logic [FIELD_W-1:0] div_i,
  output logic [FIELD_W-1:0] per_cnt_o,
  output logic               period_end_o
);
  logic [FIELD_W-1:0] pre_cnt_q, per_cnt_q;
  logic               tick;

  assign tick         = (pre_cnt_q == pre_i);
  assign period_end_o = run_i && tick && (per_cnt_q == div_i);
  assign per_cnt_o    = per_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      per_cnt_q <= '0;
    end else if (load_i || !run_i) begin
      pre_cnt_q <= '0;
      per_cnt_q <= '0;
    end else begin
      pre_cnt_q <= tick ? '0 : pre_cnt_q + 1'b1;
      if (tick) per_cnt_q <= (per_cnt_q == div_i) ? '0 : per_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cfg_i,
  input  logic              wr_ctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pwm_o,
  output logic              run_o,
  output logic              pend_o,
  output logic [DATA_W-1:0] rd_cfg_o,
  output logic [DATA_W-1:0] rd_ctl_o
);
  pwm_cfg_t           sh_q, sh_n, sh_d, ac_q;
  logic               sh_en_q, en_n, pend_q, pend_n, run_q;
  logic               apply, stop, period_end;
  logic [FIELD_W-1:0] per_cnt;

  always_comb begin
    sh_n = sh_q;
    if (wr_cfg_i) begin
      sh_n.hi  = wdata_i[2*FIELD_W-1:FIELD_W];
      sh_n.div = wdata_i[FIELD_W-1:0];
    end
    if (wr_ctl_i) sh_n.pre = wdata_i[FIELD_W-1:0];
    en_n   = wr_ctl_i ? wdata_i[EN_BIT] : sh_en_q;
    pend_n = pend_q | (wr_ctl_i & wdata_i[UPD_BIT]);
    // idle channel applies at once, running one waits for the boundary
    apply  = pend_n && (!run_q || period_end);
    stop   = apply && run_q && !en_n;
    sh_d   = sh_n;
    if (stop) begin
      sh_d.pre = STOP_PRE;
      sh_d.div = STOP_DIV;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      ac_q    <= '0;
      sh_en_q <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      sh_en_q <= en_n;
      pend_q  <= apply ? 1'b0 : pend_n;
      if (apply) begin
        ac_q  <= sh_d;
        run_q <= en_n;
      end
    end
  end

  pwm_counter u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .load_i      (apply),
    .pre_i       (ac_q.pre),
    .div_i       (ac_q.div),
    .per_cnt_o   (per_cnt),
    .period_end_o(period_end)
  );

  assign pwm_o    = run_q && (per_cnt < ac_q.hi);
  assign run_o    = run_q;
  assign pend_o   = pend_q;
  assign rd_cfg_o = {sh_q.hi, sh_q.div};
  assign rd_ctl_o = {run_q, pend_q, {PAD_W{1'b0}}, sh_q.pre};
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int NUM_WORDS = 2 * NUM_CH;

  logic [NUM_CH-1:0]             run_w, pend_w;
  logic [NUM_CH-1:0][DATA_W-1:0] rd_cfg, rd_ctl;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_cfg_i(we_i && (addr_i == ADDR_W'(2 * g))),
      .wr_ctl_i(we_i && (addr_i == ADDR_W'(2 * g + 1))),
      .wdata_i (wdata_i),
      .pwm_o   (pwm_o[g]),
      .run_o   (run_w[g]),
      .pend_o  (pend_w[g]),
      .rd_cfg_o(rd_cfg[g]),
      .rd_ctl_o(rd_ctl[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = i[0] ? rd_ctl[i/2] : rd_cfg[i/2];
    end
  end
endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_i,
  input logic [NUM_CH-1:0] pwm_i,
  input logic [NUM_CH-1:0] run_i,
  input logic [NUM_CH-1:0] pend_i
);
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= 2 * NUM_CH) |-> (rdata_i == '0)); // R10

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_i[g]) |-> !pwm_i[g]); // R8

    AST_STOP_BY_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_i[g]) |-> ($past(pend_i[g]) ||
        $past(we_i && addr_i == ADDR_W'(2 * g + 1) && wdata_i[30]))); // R5

    AST_IDLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(2 * g + 1) && wdata_i[30] && wdata_i[31] && !run_i[g])
      |=> run_i[g]); // R7

    AST_PEND_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_i[g]) |-> !pend_i[g]); // R6
  end
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_i(rdata_o),
  .pwm_i  (pwm_o),
  .run_i  (run_w),
  .pend_i (pend_w)
);

// File: tb/tb_pwm_ctrl.sv
module tb_pwm_ctrl;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] pwm;

  pwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  typedef struct { int unsigned at; int ch; bit val; string tag; } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // expected level from R2/R3
  function automatic bit wave(int off, int pre, int div, int hi);
    int per = (pre + 1) * (div + 1);
    return (off % per) < hi * (pre + 1);
  endfunction

  task automatic push_wave(int ch, int unsigned base, int unsigned from, int unsigned to,
                           int pre, int div, int hi, string tag);
    for (int unsigned a = from; a <= to; a++) begin
      item_t it;
      it.at = a; it.ch = ch; it.val = wave(int'(a - base), pre, div, hi); it.tag = tag;
      if (a > cyc) q.push_back(it);
    end
  endtask

  task automatic push_level(int ch, int unsigned from, int unsigned to, bit v, string tag);
    for (int unsigned a = from; a <= to; a++) begin
      item_t it;
      it.at = a; it.ch = ch; it.val = v; it.tag = tag;
      if (a > cyc) q.push_back(it);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    for (int i = 0; i < q.size(); ) begin
      if (q[i].at == cyc) begin
        chk(pwm[q[i].ch] == q[i].val, q[i].tag, 32'(pwm[q[i].ch]), 32'(q[i].val));
        q.delete(i);
      end else i++;
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    summary();
  end

  initial begin
    int unsigned w0, u, s, u2, s3, w1, w2;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(pwm == '0, "R11 outputs low in reset", 32'(pwm), 0);
    for (int a = 0; a < 2 * NUM_CH; a++) rd(a, 32'h0, "R11 register cleared");
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pwm == '0, "R11 outputs low after reset", 32'(pwm), 0);

    // R7 R2 R3: ch0 prescale 1, divider 4, high 2 -> period 10, high 4
    wr(0, {16'd2, 16'd4});
    chk(pwm[0] == 1'b0, "R4 config write alone does not start", 32'(pwm[0]), 0);
    wr(1, 32'hC000_0001);
    w0 = cyc;
    chk(pwm[0] == 1'b1, "R7 immediate start", 32'(pwm[0]), 1);
    push_wave(0, w0, w0 + 1, w0 + 30, 1, 4, 2, "R2 R3 period and high time");
    drain();
    rd(0, {16'd2, 16'd4}, "R1 config readback");
    rd(1, 32'h8000_0001, "R1 R6 control readback, no pending");

    // R4: writes without update
    wr(0, {16'd4, 16'd4});
    wr(1, 32'h8000_0003);
    push_wave(0, w0, cyc + 1, cyc + 25, 1, 4, 2, "R4 waveform unchanged");
    drain();
    rd(0, {16'd4, 16'd4}, "R4 shadow config visible");
    rd(1, 32'h8000_0003, "R4 shadow prescale visible");

    // R5 R6: update lands mid-period at phase 4
    wr(0, {16'd1, 16'd2});
    while (((cyc - w0) % 10) != 2) @(negedge clk);
    wr(1, 32'hC000_0000);
    u = cyc;
    s = w0 + ((u - w0 + 9) / 10) * 10;
    rd(1, 32'hC000_0000, "R6 update pending");
    push_wave(0, w0, u + 1, s - 1, 1, 4, 2, "R5 old period completes");
    push_wave(0, s, s, s + 11, 0, 2, 1, "R5 new settings from boundary");
    drain();
    rd(1, 32'h8000_0000, "R6 pending cleared");

    // R8 R9: graceful stop, period 3 now
    while (((cyc - s) % 3) != 2) @(negedge clk);
    wr(1, 32'h4000_0000);
    u2 = cyc;
    s3 = s + ((u2 - s + 2) / 3) * 3;
    chk(32'(s3 - u2) == 32'd2, "R8 stop scheduled at boundary", s3 - u2, 2);
    rd(1, 32'hC000_0000, "R8 live enable until boundary");
    push_level(0, s3, s3 + 9, 1'b0, "R8 low after stop");
    drain();
    rd(1, 32'h0000_0000, "R9 prescale reset to 0");
    rd(0, {16'd1, 16'd1}, "R9 divider reset to 1");

    // R3 saturation: high equals period (prescale 2, divider 3, high 4)
    wr(2, {16'd4, 16'd3});
    wr(3, 32'hC000_0002);
    w1 = cyc;
    chk(pwm[1] == 1'b1, "R7 ch1 start", 32'(pwm[1]), 1);
    push_wave(1, w1, w1 + 1, w1 + 24, 2, 3, 4, "R3 saturated high");
    push_level(0, w1 + 1, w1 + 24, 1'b0, "R12 stopped channel stays low");
    drain();
    rd(2, {16'd4, 16'd3}, "R1 ch1 config readback");
    rd(3, 32'h8000_0002, "R1 ch1 control readback");

    // R12: ch2 toggles every cycle beside saturated ch1
    wr(4, {16'd1, 16'd1});
    wr(5, 32'hC000_0000);
    w2 = cyc;
    push_wave(2, w2, w2 + 1, w2 + 20, 0, 1, 1, "R12 ch2 toggling");
    push_level(1, w2 + 1, w2 + 20, 1'b1, "R12 ch1 unaffected");
    drain();

    // R3 zero high count: running but low
    wr(6, {16'd0, 16'd3});
    wr(7, 32'hC000_0000);
    push_level(3, cyc + 1, cyc + 12, 1'b0, "R3 zero high count low");
    drain();
    rd(7, 32'h8000_0000, "R3 ch3 running with zero high");

    // R10 unmapped words
    for (int a = 2 * NUM_CH; a < (1 << ADDR_W); a++) rd(a, 32'h0, "R10 unmapped read zero");

    summary();
  end
endmodule